// File: doc/BRIEF.md
# Continuous-Fill Nine-Bit Serial Transmitter

This block is an asynchronous serial transmitter whose line can be kept busy all the time. Burst traffic on a quiet line can couple into nearby analog circuits, so when its source has nothing to send it can keep sending filler frames. Payload bytes arrive over a valid/ready handshake. Each byte goes out as a nine-bit frame with the ninth bit set. When no byte is waiting, a fixed filler byte (0xAA) goes out instead, with the ninth bit cleared. A receiver that accepts only frames with the ninth bit set, the usual address-filter arrangement, then discards the fillers with no software work.

A mode input selects the other behaviour. With filling off, the transmitter stops after the last pending frame and deasserts its output enable, so another device can drive a shared wire. The next time it starts, it drives the line high for one bit period before the first start bit. The bit rate is set by a clock divisor that feeds a 16x oversampling tick. Even or odd parity and a second stop bit can be selected. All framing settings are taken at the moment a frame is loaded.

Top module: `fill_uart_tx`

## Requirements
- R1: During and after reset, with no data offered and filling off, tx_oe is 0, tx_o is 1 and in_ready is 1.
- R2: A frame is a start bit of 0, then the 8 data bits LSB first, then the ninth bit, then the optional parity bit, then the stop bits of 1. Each bit lasts 16*(divisor+1) clock cycles.
- R3: A byte accepted on the input is sent with the ninth bit equal to 1.
- R4: With fill_mode=1 and no byte offered at the end of a frame, a filler frame carrying 0xAA with the ninth bit 0 starts in the very next bit slot, so the line never idles.
- R5: A byte offered while a frame is in progress is sent as the next frame. The frame in progress runs to its last stop bit unchanged.
- R6: With fill_mode=0 and no byte offered at the end of a frame, tx_oe goes to 0 after the last stop bit. While tx_oe is 0, tx_o is 1.
- R7: After the output was released, tx_oe rises together with a high line. The line stays high for exactly one bit period before the start bit.
- R8: parity_sel selects the parity: 2'b00 or 2'b11 is none, 2'b01 is even, 2'b10 is odd. The parity bit covers the 8 data bits and the ninth bit, and it sits directly after the ninth bit.
- R9: two_stop=1 sends two stop bits instead of one. The next frame follows the second stop bit with no gap.
- R10: in_ready is 1 while the output is released, and during the final bit-tick cycle of a frame. A byte taken at a frame end starts in the very next bit slot, and tx_oe stays 1 in between.
- R11: A change of parity_sel or two_stop while a frame is in progress does not alter that frame. It takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | DIV_W | Clock cycles per oversampling tick, minus one |
| fill_mode | input | 1 | 1: send filler frames when empty; 0: release the line when empty |
| parity_sel | input | 2 | Parity choice, encoded as in R8 |
| two_stop | input | 1 | 1: two stop bits |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken when in_valid is also 1 |
| tx_o | output | 1 | Serial line data |
| tx_oe | output | 1 | Line driver enable; 0 releases the wire |

## Verification
The bench decodes every frame at mid-bit and counts the clocks between the last stop bit and the next start edge. A transmitter that idled, or that added an extra stop bit between back-to-back frames, shows a wrong gap. A byte is pushed halfway through a filler frame. A design that aborted the filler would corrupt that frame, and one that put the payload behind a further filler would send the wrong frame next. Parity and the stop count are switched mid-frame to catch a design that reads its settings live rather than at load time. After a release, the bench counts the high bit slot before the start bit; a missing or shortened wake slot, or tx_oe left asserted when the data runs out, shows there.

// File: rtl/ufill_pkg.sv
package ufill_pkg;
    localparam int DATA_W    = 8;
    localparam int NINTH_POS = DATA_W + 1;
    localparam int PAR_POS   = DATA_W + 2;
    localparam int FRAME_MAX = DATA_W + 5;
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int BASE_LEN  = DATA_W + 3;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAKE  = 2'd1,
        ST_SHIFT = 2'd2
    } ufill_state_e;
endpackage

// File: rtl/ufill_baud.sv
module ufill_baud #(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_tick
);
    localparam int OS_W = $clog2(OVS);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [OS_W-1:0]  os;
    } baud_t;

    baud_t cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        bit_tick = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q.pre == divisor) begin
            cnt_d.pre = '0;
            if (cnt_q.os == OS_W'(OVS - 1)) begin
                cnt_d.os = '0;
                bit_tick = 1'b1;
            end else begin
                cnt_d.os = cnt_q.os + 1'b1;
            end
        end else begin
            cnt_d.pre = cnt_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ufill_framer.sv
module ufill_framer
    import ufill_pkg::*;
(
    input  logic [DATA_W-1:0]    dat_i,
    input  logic                 ninth_i,
    input  logic [1:0]           par_sel_i,
    input  logic                 two_stop_i,
    output logic [FRAME_MAX-1:0] frame_o,
    output logic [LEN_W-1:0]     len_o
);
    logic par_en;
    logic par_bit;

    always_comb begin
        par_en  = (par_sel_i == PAR_EVEN) || (par_sel_i == PAR_ODD);
        par_bit = (^{ninth_i, dat_i}) ^ (par_sel_i == PAR_ODD);

        frame_o                = '1;
        frame_o[0]             = 1'b0;
        frame_o[DATA_W:1]      = dat_i;
        frame_o[NINTH_POS]     = ninth_i;
        if (par_en) frame_o[PAR_POS] = par_bit;

        len_o = LEN_W'(BASE_LEN) + LEN_W'(par_en) + LEN_W'(two_stop_i);
    end
endmodule

// File: rtl/ufill_ctrl.sv
module ufill_ctrl
    import ufill_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 fill_mode,
    input  logic                 in_valid,
    input  logic [FRAME_MAX-1:0] pay_frame,
    input  logic [LEN_W-1:0]     pay_len,
    input  logic [FRAME_MAX-1:0] fil_frame,
    input  logic [LEN_W-1:0]     fil_len,
    output logic                 in_ready,
    output logic                 run,
    output logic                 tx_o,
    output logic                 tx_oe
);
    typedef struct packed {
        ufill_state_e         state;
        logic [FRAME_MAX-1:0] sh;
        logic [LEN_W-1:0]     len;
        logic [LEN_W-1:0]     idx;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = 1'b0;
        unique case (st_q.state)
            ST_OFF: begin
                in_ready = 1'b1;
                st_d.idx = '0;
                if (in_valid) begin
                    st_d.sh    = pay_frame;
                    st_d.len   = pay_len;
                    st_d.state = ST_WAKE;
                end else if (fill_mode) begin
                    st_d.sh    = fil_frame;
                    st_d.len   = fil_len;
                    st_d.state = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (bit_tick) begin
                    st_d.state = ST_SHIFT;
                    st_d.idx   = '0;
                end
            end
            ST_SHIFT: begin
                if (bit_tick) begin
                    if (st_q.idx == st_q.len - 1'b1) begin
                        in_ready = 1'b1;
                        st_d.idx = '0;
                        if (in_valid) begin
                            st_d.sh  = pay_frame;
                            st_d.len = pay_len;
                        end else if (fill_mode) begin
                            st_d.sh  = fil_frame;
                            st_d.len = fil_len;
                        end else begin
                            st_d.state = ST_OFF;
                        end
                    end else begin
                        st_d.sh  = {1'b1, st_q.sh[FRAME_MAX-1:1]};
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
            end
            default: st_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_OFF;
            st_q.sh    <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run   = (st_q.state != ST_OFF);
    assign tx_oe = (st_q.state != ST_OFF);
    assign tx_o  = (st_q.state == ST_SHIFT) ? st_q.sh[0] : 1'b1;
endmodule

// File: rtl/fill_uart_tx.sv
module fill_uart_tx
    import ufill_pkg::*;
#(
    parameter int          DIV_W     = 16,
    parameter int          OVS       = 16,
    parameter logic [7:0]  FILL_BYTE = 8'hAA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             fill_mode,
    input  logic [1:0]       parity_sel,
    input  logic             two_stop,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             tx_o,
    output logic             tx_oe
);
    logic                 bit_tick;
    logic                 run;
    logic [FRAME_MAX-1:0] pay_frame, fil_frame;
    logic [LEN_W-1:0]     pay_len, fil_len;

    ufill_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .divisor  (divisor),
        .bit_tick (bit_tick)
    );

    ufill_framer u_pay (
        .dat_i      (in_data),
        .ninth_i    (1'b1),
        .par_sel_i  (parity_sel),
        .two_stop_i (two_stop),
        .frame_o    (pay_frame),
        .len_o      (pay_len)
    );

    ufill_framer u_fil (
        .dat_i      (FILL_BYTE),
        .ninth_i    (1'b0),
        .par_sel_i  (parity_sel),
        .two_stop_i (two_stop),
        .frame_o    (fil_frame),
        .len_o      (fil_len)
    );

    ufill_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .fill_mode (fill_mode),
        .in_valid  (in_valid),
        .pay_frame (pay_frame),
        .pay_len   (pay_len),
        .fil_frame (fil_frame),
        .fil_len   (fil_len),
        .in_ready  (in_ready),
        .run       (run),
        .tx_o      (tx_o),
        .tx_oe     (tx_oe)
    );
endmodule

// File: rtl/ufill_chk.sv
module ufill_chk (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic tx_o,
    input logic tx_oe
);
    // R6: a released line reads high
    assert_released_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> tx_o);

    // R7: driver comes back on with a high line
    assert_wake_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> tx_o);

    // R6: release only after a high stop bit
    assert_release_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> $past(tx_o));

    // R10: a frame-end ready is followed by a new start bit or a release
    assert_ready_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && tx_oe) |=> (!tx_oe || !tx_o));

    // R1: released output always accepts
    assert_idle_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> in_ready);

    // R2: start edges only while driving
    assert_fall_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_o) |-> tx_oe);
endmodule

bind fill_uart_tx ufill_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .tx_o     (tx_o),
    .tx_oe    (tx_oe)
);

// File: tb/sim_fill_uart_tx.sv
`timescale 1ns/1ps
module sim_fill_uart_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] divisor = '0;
    logic        fill_mode = 1'b0;
    logic [1:0]  parity_sel = 2'b00;
    logic        two_stop = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, tx_o, tx_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int bitp   = 16;
    bit done   = 1'b0;
    logic [7:0] txq[$];

    always #4 clk = ~clk;

    fill_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .fill_mode(fill_mode),
        .parity_sel(parity_sel), .two_stop(two_stop), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .tx_o(tx_o), .tx_oe(tx_oe)
    );

    always @(negedge clk) begin
        in_valid <= (txq.size() > 0);
        in_data  <= (txq.size() > 0) ? txq[0] : 8'h00;
    end
    always @(posedge clk)
        if (in_valid && in_ready && txq.size() > 0) void'(txq.pop_front());

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog all-reqs actual=%0d cycles expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] mk(input logic [7:0] d, input logic n9,
                                       input logic [1:0] ps, input logic ts, output int len);
        logic [12:0] f;
        logic pe;
        f = '1; f[0] = 1'b0; f[8:1] = d; f[9] = n9;
        pe = (ps == 2'b01) || (ps == 2'b10);
        if (pe) f[10] = (^{n9, d}) ^ (ps == 2'b10);
        len = 11 + int'(pe) + int'(ts);
        return f;
    endfunction

    task automatic grab(input int n, output logic [12:0] b, output int gap,
                        output int wake, output int drop);
        b = '1; gap = 0; wake = 0; drop = 0;
        do begin
            @(negedge clk);
            gap++;
            if (tx_oe && tx_o) wake++;
            if (!tx_oe) drop++;
        end while (!(tx_oe && !tx_o));
        repeat (bitp / 2) @(negedge clk);
        b[0] = tx_o;
        for (int i = 1; i < n; i++) begin
            repeat (bitp) @(negedge clk);
            b[i] = tx_o;
        end
    endtask

    task automatic expect_frame(input string req, input logic [7:0] d, input logic n9,
                                output int gap, output int wake, output int drop);
        logic [12:0] got, ex;
        int len;
        ex = mk(d, n9, parity_sel, two_stop, len);
        grab(len, got, gap, wake, drop);
        chk((got & ((13'd1 << len) - 1)) == (ex & ((13'd1 << len) - 1)), req,
            longint'(got), longint'(ex));
    endtask

    task automatic wait_release();
        int k = 0;
        while (tx_oe && k < 4000) begin @(negedge clk); k++; end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(tx_oe == 1'b0 && tx_o == 1'b1, "R1 in reset", {tx_oe, tx_o}, 2'b01);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(tx_oe == 1'b0 && tx_o == 1'b1, "R1 after reset", {tx_oe, tx_o}, 2'b01);
        chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    endtask

    task automatic t_single();
        int g, w, dr;
        txq.push_back(8'h3C);
        expect_frame("R2 R3 single payload", 8'h3C, 1'b1, g, w, dr);
        chk(w == bitp, "R7 wake slot length", w, bitp);
        repeat (bitp) @(negedge clk);
        chk(tx_oe == 1'b0 && tx_o == 1'b1, "R6 release after frame", {tx_oe, tx_o}, 2'b01);
        chk(in_ready == 1'b1, "R10 ready when released", in_ready, 1);
    endtask

    task automatic t_b2b();
        int g, w, dr;
        txq.push_back(8'h81);
        txq.push_back(8'h7E);
        expect_frame("R3 first of pair", 8'h81, 1'b1, g, w, dr);
        expect_frame("R10 second of pair", 8'h7E, 1'b1, g, w, dr);
        chk(g == bitp / 2 && dr == 0, "R10 no gap between payloads", g, bitp / 2);
        wait_release();
    endtask

    task automatic t_div();
        int g, w, dr;
        divisor = 16'd2; bitp = 48;
        txq.push_back(8'hE1);
        expect_frame("R2 divisor 2 frame", 8'hE1, 1'b1, g, w, dr);
        chk(w == 48, "R2 R7 bit period with divisor 2", w, 48);
        wait_release();
        divisor = 16'd0; bitp = 16;
    endtask

    task automatic t_fill();
        int g, w, dr;
        fill_mode = 1'b1;
        expect_frame("R4 first filler", 8'hAA, 1'b0, g, w, dr);
        expect_frame("R4 second filler", 8'hAA, 1'b0, g, w, dr);
        chk(g == bitp / 2 && dr == 0, "R4 filler follows without gap", g, bitp / 2);
        fork
            expect_frame("R5 filler not aborted", 8'hAA, 1'b0, g, w, dr);
            begin repeat (bitp * 5) @(negedge clk); txq.push_back(8'hC3); end
        join
        expect_frame("R5 payload next frame", 8'hC3, 1'b1, g, w, dr);
        chk(g == bitp / 2, "R5 payload gap", g, bitp / 2);
        expect_frame("R4 filler resumes", 8'hAA, 1'b0, g, w, dr);
    endtask

    task automatic t_parity();
        int g, w, dr;
        parity_sel = 2'b01;
        expect_frame("R8 even filler", 8'hAA, 1'b0, g, w, dr);
        parity_sel = 2'b10;
        expect_frame("R8 odd filler", 8'hAA, 1'b0, g, w, dr);
        txq.push_back(8'h55);
        expect_frame("R8 odd payload", 8'h55, 1'b1, g, w, dr);
        expect_frame("R8 odd filler gap", 8'hAA, 1'b0, g, w, dr);
        chk(g == bitp / 2, "R8 twelve-bit frame length", g, bitp / 2);
        parity_sel = 2'b11;
        expect_frame("R8 code 11 is none", 8'hAA, 1'b0, g, w, dr);
        parity_sel = 2'b00;
        expect_frame("R8 none", 8'hAA, 1'b0, g, w, dr);
    endtask

    task automatic t_live_cfg();
        int g, w, dr;
        fork
            expect_frame("R11 frame keeps load-time parity", 8'hAA, 1'b0, g, w, dr);
            begin repeat (bitp * 4) @(negedge clk); parity_sel = 2'b01; two_stop = 1'b1; end
        join
        expect_frame("R11 next frame uses new config", 8'hAA, 1'b0, g, w, dr);
        chk(g == bitp / 2, "R11 old frame length kept", g, bitp / 2);
        parity_sel = 2'b00;
    endtask

    task automatic t_two_stop();
        int g, w, dr;
        two_stop = 1'b1;
        expect_frame("R9 two stop filler", 8'hAA, 1'b0, g, w, dr);
        txq.push_back(8'h0F);
        expect_frame("R9 two stop payload", 8'h0F, 1'b1, g, w, dr);
        expect_frame("R9 following frame", 8'hAA, 1'b0, g, w, dr);
        chk(g == bitp / 2, "R9 gap after second stop", g, bitp / 2);
        two_stop = 1'b0;
        expect_frame("R9 back to one stop", 8'hAA, 1'b0, g, w, dr);
        fill_mode = 1'b0;
        wait_release();
        chk(tx_oe == 1'b0, "R6 release when fill turned off", tx_oe, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_b2b();
        t_div();
        t_fill();
        t_parity();
        t_live_cfg();
        t_two_stop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule